// File: doc/BRIEF.md
# Reorder Buffer with Budgeted Squash Walk

This block tracks in-flight instructions of an out-of-order core in program order. Dispatch writes a new entry at the tail, carrying its program counter, next program counter and sequence number. Completion logic marks an entry ready by index, and the commit stage retires the oldest entry from the head. The block reports how many entries are free, whether the head may commit, and the identifying fields of the oldest and newest entries.

A squash request names a sequence number. From the newest entry, the block walks toward older entries with a fixed budget of entries per cycle. Every entry it passes is flagged both squashed and ready, so it leaves through the ordinary retire path, where a separate output marks it as discarded. The walk stops at the named instruction, which is kept. It also stops at the head when the named instruction has already left. While a walk runs, dispatch is held off. A second request during a walk can only move the stop point to an older instruction.

Top module: `rob_squash_tracker`

## Requirements
- R1: After reset, `free_cnt` equals DEPTH, `sq_done` is 1 and `head_ready` is 0.
- R2: An unstalled `alloc_valid` writes the entry at index `alloc_idx` and lowers `free_cnt` by one. `tail_pc`/`tail_seq` show the newest entry and `head_pc`/`head_npc`/`head_seq` show the oldest.
- R3: `alloc_stall` is 1 when the buffer is full, while a walk is running, or while `sq_valid` is high. An allocation made while stalled changes nothing.
- R4: `head_ready` is 1 only when the buffer is non-empty and the head entry's ready flag is set. The flag is set through `done_valid`/`done_idx` or by the squash walk.
- R5: `retire_req` on a non-empty buffer removes the head entry and raises `free_cnt` by one. The retire is reported in the same cycle: `retire_squashed` is 1 if the entry was squashed, and `retire_commit` is 1 otherwise.
- R6: `retire_req` on an empty buffer raises `retire_err` in the same cycle, raises neither retire output and leaves `free_cnt` unchanged.
- R7: A `sq_valid` accepted while idle makes `sq_done` 0 from the next cycle. The walk begins at the newest entry.
- R8: Each walk cycle visits up to SQ_W entries, from newest to oldest, and marks each one squashed and ready. An entry whose sequence number equals the target is neither marked nor passed, and the walk ends on it. With m entries newer than the target, `sq_done` returns to 1 after floor(m/SQ_W)+1 walk cycles.
- R9: If no entry matches, the walk marks the head as well and then ends. With n entries this takes floor((n-1)/SQ_W)+1 cycles. On an empty buffer the walk ends after one cycle.
- R10: During a walk, a new `sq_valid` whose sequence number is smaller (older, compared as unsigned) than the current target replaces the target, and the walk continues toward it. A request with an equal or larger sequence number is ignored.
- R11: A retire and a walk step may fall in the same cycle. An entry retired before the walk reaches it is reported as committed. An entry retired in the same cycle the walk marks it is also reported as committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch request |
| alloc_pc | input | PC_W | PC of the new instruction |
| alloc_npc | input | PC_W | Next PC of the new instruction |
| alloc_seq | input | SEQ_W | Sequence number of the new instruction |
| alloc_stall | output | 1 | Dispatch refused this cycle |
| alloc_idx | output | log2(DEPTH) | Index the next allocation writes |
| done_valid | input | 1 | Mark an entry ready to commit |
| done_idx | input | log2(DEPTH) | Index of the entry to mark |
| retire_req | input | 1 | Retire the head entry |
| retire_commit | output | 1 | Head leaves as a committed instruction |
| retire_squashed | output | 1 | Head leaves as a discarded instruction |
| retire_err | output | 1 | Retire requested on an empty buffer |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Sequence number of the instruction to keep |
| sq_done | output | 1 | No walk in progress |
| free_cnt | output | log2(DEPTH)+1 | Number of free entries |
| head_ready | output | 1 | Head entry may retire |
| head_pc | output | PC_W | PC of the oldest entry |
| head_npc | output | PC_W | Next PC of the oldest entry |
| head_seq | output | SEQ_W | Sequence number of the oldest entry |
| tail_pc | output | PC_W | PC of the newest entry |
| tail_seq | output | SEQ_W | Sequence number of the newest entry |

## Verification
Retirement at the head and the squash walk's marking can fall in the same cycle, and so can a squash and a dispatch. The bench fills the buffer and asserts `retire_req` every cycle from the cycle the squash is requested. For each entry it computes, from the walk budget, the cycle in which the walk reaches that entry. It expects a squashed report exactly when that cycle comes before the entry's retire cycle, so the collision at the head is judged as a commit. A squash raised together with a dispatch is judged through `alloc_stall` in that cycle.

// File: rtl/rob_sq_pkg.sv
package rob_sq_pkg;
   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_req,
   input  logic          alloc_block,
   input  logic          retire_req,
   output logic [PW-1:0] head_ptr,
   output logic [PW-1:0] tail_ptr,
   output logic [PW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          alloc_fire,
   output logic          retire_fire
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rob_ptr_ctrl: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   assign count       = tail_ptr - head_ptr;
   assign full        = (count == PW'(DEPTH));
   assign empty       = (count == '0);
   assign alloc_fire  = alloc_req && !alloc_block && !full;
   assign retire_fire = retire_req && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_ptr <= '0;
         tail_ptr <= '0;
      end else begin
         if (alloc_fire)  tail_ptr <= tail_ptr + PW'(1);
         if (retire_fire) head_ptr <= head_ptr + PW'(1);
      end
   end

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PW'(DEPTH));
endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk
   import rob_sq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SQ_W  = 2,
   parameter int SEQ_W = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq,
   input  logic [PW-1:0]    head_ptr,
   input  logic [PW-1:0]    tail_ptr,
   input  logic [SEQ_W-1:0] entry_seq [DEPTH],
   output logic             busy,
   output logic [DEPTH-1:0] mark
);
   generate
      if (SQ_W < 1 || SQ_W > DEPTH) begin : g_bad_width
         $error("rob_squash_walk: SQ_W must lie between 1 and DEPTH");
      end
   endgenerate

   walk_state_e      state;
   logic [SEQ_W-1:0] target;
   logic [PW-1:0]    walk_ptr;
   logic [PW-1:0]    avail;
   logic [DEPTH-1:0] hit;
   logic [DEPTH-1:0] step_mark;
   logic             step_stop;
   logic             go;
   logic             start;
   logic             retarget;

   assign busy     = (state == WALK_RUN);
   assign start    = !busy && sq_valid;
   assign retarget = busy && sq_valid && (sq_seq < target);
   // entries from the head up to the walk pointer, inclusive
   assign avail    = walk_ptr + PW'(1) - head_ptr;

   for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign hit[g] = (entry_seq[g] == target);
   end

   always_comb begin
      step_mark = '0;
      step_stop = (avail == '0);
      go        = (avail != '0);
      for (int i = 0; i < SQ_W; i++) begin
         if (go) begin
            if (hit[AW'(walk_ptr[AW-1:0] - AW'(i))]) begin
               step_stop = 1'b1;
               go        = 1'b0;
            end else begin
               step_mark[AW'(walk_ptr[AW-1:0] - AW'(i))] = 1'b1;
               if (PW'(i) == avail - PW'(1)) begin
                  step_stop = 1'b1;
                  go        = 1'b0;
               end
            end
         end
      end
   end

   assign mark = (busy && !retarget) ? step_mark : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= WALK_IDLE;
         target   <= '0;
         walk_ptr <= '0;
      end else if (start) begin
         state    <= WALK_RUN;
         target   <= sq_seq;
         walk_ptr <= tail_ptr - PW'(1);
      end else if (retarget) begin
         target   <= sq_seq;
      end else if (busy) begin
         if (step_stop) state <= WALK_IDLE;
         walk_ptr <= walk_ptr - PW'(SQ_W);
      end
   end

   // R8
   mark_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mark) <= SQ_W);

   // R7
   idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && !busy) |=> busy);

   // R9
   walk_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((tail_ptr - walk_ptr) != '0));
endmodule

// File: rtl/rob_squash_tracker.sv
module rob_squash_tracker #(
   parameter int DEPTH = 8,
   parameter int SQ_W  = 2,
   parameter int PC_W  = 32,
   parameter int SEQ_W = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [PC_W-1:0]  alloc_pc,
   input  logic [PC_W-1:0]  alloc_npc,
   input  logic [SEQ_W-1:0] alloc_seq,
   output logic             alloc_stall,
   output logic [AW-1:0]    alloc_idx,
   input  logic             done_valid,
   input  logic [AW-1:0]    done_idx,
   input  logic             retire_req,
   output logic             retire_commit,
   output logic             retire_squashed,
   output logic             retire_err,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq,
   output logic             sq_done,
   output logic [PW-1:0]    free_cnt,
   output logic             head_ready,
   output logic [PC_W-1:0]  head_pc,
   output logic [PC_W-1:0]  head_npc,
   output logic [SEQ_W-1:0] head_seq,
   output logic [PC_W-1:0]  tail_pc,
   output logic [SEQ_W-1:0] tail_seq
);
   generate
      if (PC_W < 1 || SEQ_W < 1) begin : g_bad_fields
         $error("rob_squash_tracker: field widths must be positive");
      end
   endgenerate

   logic [PW-1:0]    head_ptr, tail_ptr, count;
   logic             full, empty, alloc_fire, retire_fire;
   logic             walk_busy;
   logic [DEPTH-1:0] walk_mark;
   logic [DEPTH-1:0] rdy_q, sqf_q;
   logic [PC_W-1:0]  pc_q   [DEPTH];
   logic [PC_W-1:0]  npc_q  [DEPTH];
   logic [SEQ_W-1:0] seq_q  [DEPTH];
   logic [AW-1:0]    head_idx, newest_idx;

   rob_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_req   (alloc_valid),
      .alloc_block (walk_busy || sq_valid),
      .retire_req  (retire_req),
      .head_ptr    (head_ptr),
      .tail_ptr    (tail_ptr),
      .count       (count),
      .full        (full),
      .empty       (empty),
      .alloc_fire  (alloc_fire),
      .retire_fire (retire_fire)
   );

   rob_squash_walk #(.DEPTH(DEPTH), .SQ_W(SQ_W), .SEQ_W(SEQ_W)) i_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .sq_valid  (sq_valid),
      .sq_seq    (sq_seq),
      .head_ptr  (head_ptr),
      .tail_ptr  (tail_ptr),
      .entry_seq (seq_q),
      .busy      (walk_busy),
      .mark      (walk_mark)
   );

   assign head_idx   = head_ptr[AW-1:0];
   assign newest_idx = AW'(tail_ptr[AW-1:0] - AW'(1));
   assign alloc_idx  = tail_ptr[AW-1:0];

   // entry payload: written once at dispatch, no reset needed
   always_ff @(posedge clk) begin
      if (alloc_fire) begin
         pc_q[alloc_idx]  <= alloc_pc;
         npc_q[alloc_idx] <= alloc_npc;
         seq_q[alloc_idx] <= alloc_seq;
      end
   end

   // per-entry status flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= '0;
         sqf_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (alloc_fire && alloc_idx == AW'(e)) begin
               rdy_q[e] <= 1'b0;
               sqf_q[e] <= 1'b0;
            end else begin
               if (walk_mark[e]) begin
                  rdy_q[e] <= 1'b1;
                  sqf_q[e] <= 1'b1;
               end
               if (done_valid && done_idx == AW'(e)) rdy_q[e] <= 1'b1;
            end
         end
      end
   end

   assign alloc_stall     = full || walk_busy || sq_valid;
   assign retire_err      = retire_req && empty;
   assign retire_commit   = retire_fire && !sqf_q[head_idx];
   assign retire_squashed = retire_fire && sqf_q[head_idx];
   assign sq_done         = !walk_busy;
   assign free_cnt        = PW'(DEPTH) - count;
   assign head_ready      = !empty && rdy_q[head_idx];
   assign head_pc         = pc_q[head_idx];
   assign head_npc        = npc_q[head_idx];
   assign head_seq        = seq_q[head_idx];
   assign tail_pc         = pc_q[newest_idx];
   assign tail_seq        = seq_q[newest_idx];

   // R3
   walk_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_busy |-> !alloc_fire);

   // R5
   squashed_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_squashed |-> head_ready);
endmodule

// File: tb/test_rob_squash_tracker.sv
module test_rob_squash_tracker;
   localparam int DEPTH = 8;
   localparam int SQW   = 2;
   localparam int PCW   = 32;
   localparam int SQN   = 16;
   localparam int AW    = 3;
   localparam int PW    = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n;
   logic           alloc_valid;
   logic [PCW-1:0] alloc_pc, alloc_npc;
   logic [SQN-1:0] alloc_seq;
   logic           alloc_stall;
   logic [AW-1:0]  alloc_idx;
   logic           done_valid;
   logic [AW-1:0]  done_idx;
   logic           retire_req, retire_commit, retire_squashed, retire_err;
   logic           sq_valid;
   logic [SQN-1:0] sq_seq;
   logic           sq_done;
   logic [PW-1:0]  free_cnt;
   logic           head_ready;
   logic [PCW-1:0] head_pc, head_npc, tail_pc;
   logic [SQN-1:0] head_seq, tail_seq;

   rob_squash_tracker #(.DEPTH(DEPTH), .SQ_W(SQW), .PC_W(PCW), .SEQ_W(SQN)) i_rob_squash_tracker (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_npc(alloc_npc),
      .alloc_seq(alloc_seq), .alloc_stall(alloc_stall), .alloc_idx(alloc_idx),
      .done_valid(done_valid), .done_idx(done_idx),
      .retire_req(retire_req), .retire_commit(retire_commit),
      .retire_squashed(retire_squashed), .retire_err(retire_err),
      .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_done(sq_done),
      .free_cnt(free_cnt), .head_ready(head_ready),
      .head_pc(head_pc), .head_npc(head_npc), .head_seq(head_seq),
      .tail_pc(tail_pc), .tail_seq(tail_seq)
   );

   int checks = 0;
   int fails  = 0;
   int seqc   = 100;
   logic [SQN-1:0] s_arr [DEPTH];
   logic [AW-1:0]  i_arr [DEPTH];

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   task automatic alloc_one(input int slot);
      alloc_valid = 1'b1;
      alloc_seq   = SQN'(seqc);
      alloc_pc    = PCW'(seqc * 4);
      alloc_npc   = PCW'(seqc * 4 + 4);
      #1;
      s_arr[slot] = SQN'(seqc);
      i_arr[slot] = alloc_idx;
      @(negedge clk);
      alloc_valid = 1'b0;
      seqc++;
   endtask

   task automatic fill(input int n, input bit detail);
      for (int i = 0; i < n; i++) begin
         alloc_one(i);
         if (detail) begin
            chk("R2 free_cnt", free_cnt, DEPTH - 1 - i);
            chk("R2 tail_seq", tail_seq, s_arr[i]);
            chk("R2 tail_pc", tail_pc, s_arr[i] * 4);
            chk("R2 head_npc", head_npc, s_arr[0] * 4 + 4);
            chk("R2 head_pc", head_pc, s_arr[0] * 4);
         end
      end
   endtask

   task automatic mark_ready(input logic [AW-1:0] idx);
      done_valid = 1'b1;
      done_idx   = idx;
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   // walk cycles measured from the request edge to sq_done rising
   task automatic squash(input logic [SQN-1:0] tgt, output int cyc);
      sq_valid = 1'b1;
      sq_seq   = tgt;
      #1;
      chk("R3 stall with sq_valid", alloc_stall, 1);
      @(negedge clk);
      sq_valid = 1'b0;
      chk("R7 sq_done low", sq_done, 0);
      cyc = 0;
      while (!sq_done && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   // t < 0: every entry squashed; otherwise entries newer than slot t
   task automatic drain(input int n, input int t);
      for (int j = 0; j < n; j++) begin
         bit exp_sq;
         exp_sq = (t < 0) ? 1'b1 : (j > t);
         chk("R2 head_seq", head_seq, s_arr[j]);
         if (exp_sq) chk("R8 squashed entry ready", head_ready, 1);
         else begin
            chk("R4 head not ready", head_ready, 0);
            mark_ready(i_arr[j]);
            chk("R4 head ready after done", head_ready, 1);
         end
         retire_req = 1'b1;
         #1;
         chk("R5 retire_squashed", retire_squashed, exp_sq);
         chk("R5 retire_commit", retire_commit, !exp_sq);
         @(negedge clk);
         retire_req = 1'b0;
      end
      chk("R5 free_cnt after drain", free_cnt, DEPTH);
   endtask

   initial begin
      int cyc;
      rst_n = 1'b0; alloc_valid = 1'b0; alloc_pc = '0; alloc_npc = '0; alloc_seq = '0;
      done_valid = 1'b0; done_idx = '0; retire_req = 1'b0; sq_valid = 1'b0; sq_seq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 free_cnt", free_cnt, DEPTH);
      chk("R1 sq_done", sq_done, 1);
      chk("R1 head_ready", head_ready, 0);

      // R6: retire on empty
      retire_req = 1'b1;
      #1;
      chk("R6 retire_err", retire_err, 1);
      chk("R6 no commit", retire_commit, 0);
      chk("R6 no squashed", retire_squashed, 0);
      @(negedge clk);
      retire_req = 1'b0;
      chk("R6 free_cnt", free_cnt, DEPTH);

      // R2 and R3: fill to full, then a stalled allocation
      fill(DEPTH, 1'b1);
      chk("R3 stall when full", alloc_stall, 1);
      alloc_valid = 1'b1; alloc_seq = 16'd9999; alloc_pc = 32'd1;
      @(negedge clk);
      alloc_valid = 1'b0;
      chk("R3 ignored free_cnt", free_cnt, 0);
      chk("R3 ignored tail_seq", tail_seq, s_arr[DEPTH-1]);
      drain(DEPTH, DEPTH - 1);

      // R8 / R9 sweep over occupancy and target position
      for (int n = 0; n <= DEPTH; n++) begin
         for (int t = -1; t < n; t++) begin
            int last, expc;
            logic [SQN-1:0] tgt;
            fill(n, 1'b0);
            if (n == 0) begin
               tgt = SQN'(seqc); expc = 1;
            end else if (t < 0) begin
               tgt = s_arr[0] - 1; last = n - 1; expc = last / SQW + 1;
            end else begin
               tgt = s_arr[t]; last = n - 1 - t; expc = last / SQW + 1;
            end
            squash(tgt, cyc);
            if (t < 0) chk("R9 walk cycles", cyc, expc);
            else chk("R8 walk cycles", cyc, expc);
            drain(n, t);
         end
      end

      // R10: older retarget accepted
      fill(DEPTH, 1'b0);
      sq_valid = 1'b1; sq_seq = s_arr[4];
      @(negedge clk);
      sq_seq = s_arr[1];
      @(negedge clk);
      sq_valid = 1'b0;
      cyc = 0;
      while (!sq_done && cyc < 40) begin @(negedge clk); cyc++; end
      chk("R10 older retarget cycles", cyc, 4);
      drain(DEPTH, 1);

      // R10: newer retarget ignored
      fill(DEPTH, 1'b0);
      sq_valid = 1'b1; sq_seq = s_arr[2];
      @(negedge clk);
      sq_seq = s_arr[5];
      @(negedge clk);
      sq_valid = 1'b0;
      cyc = 0;
      while (!sq_done && cyc < 40) begin @(negedge clk); cyc++; end
      drain(DEPTH, 2);

      // R11: retire every cycle while the walk runs toward an absent target
      fill(DEPTH, 1'b0);
      sq_valid = 1'b1; sq_seq = s_arr[0] - 1;
      retire_req = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
         int visit;
         visit = 1 + (DEPTH - 1 - j) / SQW;
         #1;
         chk("R11 retire_squashed", retire_squashed, (visit < j) ? 1 : 0);
         chk("R11 retire_commit", retire_commit, (visit < j) ? 0 : 1);
         @(negedge clk);
         sq_valid = 1'b0;
      end
      retire_req = 1'b0;
      chk("R11 free_cnt", free_cnt, DEPTH);
      chk("R11 sq_done", sq_done, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule